// File: doc/BRIEF.md
# Three-Format RISC Instruction Decoder

This block turns one 32-bit instruction word into everything the execute stage needs before it can act. The word comes in three layouts. In the register layout a primary opcode of zero is followed by two source indices, a destination index, a shift amount and a 6-bit function code. In the immediate layout the opcode is followed by two register indices and a 16-bit constant. In the jump layout the opcode is followed by a 26-bit target. The decoder is purely combinational. Its outputs follow the instruction input within the same cycle and it holds no state.

A control unit reads the opcode and the function code and builds a small bundle of strobes. These strobes select the ALU operation and the second-operand source. They enable register writes, memory reads and memory writes, and give the access size and sign. They also mark conditional branches, jumps and links. A field unit extracts the indices and forms three values: the extended immediate, the byte offset for branches, and the 28-bit jump offset. The field unit also picks where the destination index comes from and blocks any write aimed at register 0. The program counter, the register file and pipelining belong to the surrounding core.

Top module: `instrDecoder`

## Requirements
- R1: `rsIdx` equals instruction bits 25..21, `rtIdx` equals bits 20..16 and `shamt` equals bits 10..6, for every instruction word.
- R2: `destIdx` is bits 15..11 when the opcode (bits 31..26) is 0. It is 31 for opcode 3 (jump-and-link). For every other opcode it is bits 20..16.
- R3: `regWrite` is 0 whenever `destIdx` is 0, even for an instruction that would otherwise write a register.
- R4: `immExt` is bits 15..0 zero-extended for opcodes 12, 13 and 14 (logical AND, OR and XOR immediate). It is bits 15..0 placed in the upper half with zeros below for opcode 15 (load upper). For all other opcodes it is bits 15..0 sign-extended.
- R5: `branchOffset` is the sign-extended bits 15..0 shifted left by 2. `jumpOffset` is bits 25..0 shifted left by 2.
- R6: For opcode 0, the function code selects `aluOp` as follows: 32/33 give 0 (add), 34/35 give 1 (subtract), 36 gives 2 (and), 37 gives 3 (or), 38 gives 4 (xor), 39 gives 5 (nor), 42 gives 6 (signed less-than), 43 gives 7 (unsigned less-than), 0 gives 8 (shift left), 2 gives 9 (logical shift right) and 3 gives 10 (arithmetic shift right). Each of these sets `regWrite` (subject to R3), and `aluSrcImm` stays 0.
- R7: The immediate ALU opcodes set `aluSrcImm` and `regWrite`, with `aluOp` as follows: 8 and 9 give 0, 10 gives 6, 11 gives 7, 12 gives 2, 13 gives 3, 14 gives 4, and 15 gives 11 (pass immediate).
- R8: The load opcodes are 32 (byte, signed), 33 (half, signed), 35 (word, signed), 36 (byte, unsigned) and 37 (half, unsigned). Each sets `memRead`, `regWrite`, `aluSrcImm` and `aluOp` 0. `memSize` is 0 for byte, 1 for half and 2 for word, and `memSigned` is set for the signed kinds.
- R9: The store opcodes are 40 (byte), 41 (half) and 43 (word). Each sets `memWrite`, `aluSrcImm` and `aluOp` 0, with `memSize` coded as in R8. A store never sets `regWrite` or `memSigned`.
- R10: Opcode 4 sets `branchEq` and opcode 5 sets `branchNe`. Both select `aluOp` 1 and write neither a register nor memory.
- R11: Opcode 2 sets `jump`. Opcode 3 sets `jump`, `jumpLink` and `regWrite`. Opcode 0 with function code 8 sets `jumpReg` and does not write a register.
- R12: An opcode not listed above, or function code that is not listed under opcode 0, sets `illegal`. In that case all enables are 0 (register write, memory read and write, branches, jumps, link), along with `aluSrcImm`, `memSize` and `memSigned`, and `aluOp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| rsIdx | output | 5 | First source register index |
| rtIdx | output | 5 | Second source register index |
| destIdx | output | 5 | Destination register index |
| shamt | output | 5 | Shift amount field |
| immExt | output | 32 | Extended immediate operand |
| branchOffset | output | 32 | Byte offset for a taken branch |
| jumpOffset | output | 28 | Byte offset within the jump region |
| aluOp | output | 4 | ALU operation code |
| aluSrcImm | output | 1 | Second ALU operand comes from immExt |
| regWrite | output | 1 | Register file write enable |
| memRead | output | 1 | Data memory read enable |
| memWrite | output | 1 | Data memory write enable |
| memSize | output | 2 | Access size: 0 byte, 1 half, 2 word |
| memSigned | output | 1 | Load result is sign-extended |
| branchEq | output | 1 | Branch when operands are equal |
| branchNe | output | 1 | Branch when operands differ |
| jump | output | 1 | Direct jump |
| jumpLink | output | 1 | Jump that saves the return address |
| jumpReg | output | 1 | Jump to the address held in a register |
| illegal | output | 1 | Instruction is not recognised |

## Verification
The block has no registers, so every output is due in the same cycle that a new word reaches `instr`. Nothing in the decode waits on a later cycle. The driver applies each word on a rising edge and queues the expected output bundle. The monitor compares the bundle at the next falling edge, half a period later, when the combinational paths have long settled and no new word has been applied. In this way each result is checked in exactly the cycle it belongs to.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int INSTR_W = 32;
  localparam int OPC_W   = 6;
  localparam int IMM_W   = 16;
  localparam int TGT_W   = 26;

  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_XOR  = 4'd4,
    ALU_NOR  = 4'd5,
    ALU_SLT  = 4'd6,
    ALU_SLTU = 4'd7,
    ALU_SLL  = 4'd8,
    ALU_SRL  = 4'd9,
    ALU_SRA  = 4'd10,
    ALU_LUI  = 4'd11
  } aluSel_e;

  typedef enum logic [1:0] { IMM_SIGN, IMM_ZERO, IMM_UPPER } immKind_e;
  typedef enum logic [1:0] { DST_RD, DST_RT, DST_LINK } dstSel_e;
  typedef enum logic [1:0] { SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2 } memSize_e;

  typedef struct packed {
    aluSel_e  aluOp;
    logic     aluSrcImm;
    logic     regWrite;
    logic     memRead;
    logic     memWrite;
    memSize_e memSize;
    logic     memSigned;
    logic     brEq;
    logic     brNe;
    logic     jump;
    logic     link;
    logic     jumpReg;
    logic     illegal;
    immKind_e immKind;
    dstSel_e  dstSel;
  } ctrlStrobes_t;

  // primary opcodes
  localparam logic [OPC_W-1:0] OP_REG   = 6'd0;
  localparam logic [OPC_W-1:0] OP_J     = 6'd2;
  localparam logic [OPC_W-1:0] OP_JAL   = 6'd3;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'd4;
  localparam logic [OPC_W-1:0] OP_BNE   = 6'd5;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'd8;
  localparam logic [OPC_W-1:0] OP_ADDIU = 6'd9;
  localparam logic [OPC_W-1:0] OP_SLTI  = 6'd10;
  localparam logic [OPC_W-1:0] OP_SLTIU = 6'd11;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'd12;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'd13;
  localparam logic [OPC_W-1:0] OP_XORI  = 6'd14;
  localparam logic [OPC_W-1:0] OP_LUI   = 6'd15;
  localparam logic [OPC_W-1:0] OP_LB    = 6'd32;
  localparam logic [OPC_W-1:0] OP_LH    = 6'd33;
  localparam logic [OPC_W-1:0] OP_LW    = 6'd35;
  localparam logic [OPC_W-1:0] OP_LBU   = 6'd36;
  localparam logic [OPC_W-1:0] OP_LHU   = 6'd37;
  localparam logic [OPC_W-1:0] OP_SB    = 6'd40;
  localparam logic [OPC_W-1:0] OP_SH    = 6'd41;
  localparam logic [OPC_W-1:0] OP_SW    = 6'd43;

  // function codes under OP_REG
  localparam logic [5:0] FN_SLL  = 6'd0;
  localparam logic [5:0] FN_SRL  = 6'd2;
  localparam logic [5:0] FN_SRA  = 6'd3;
  localparam logic [5:0] FN_JR   = 6'd8;
  localparam logic [5:0] FN_ADD  = 6'd32;
  localparam logic [5:0] FN_ADDU = 6'd33;
  localparam logic [5:0] FN_SUB  = 6'd34;
  localparam logic [5:0] FN_SUBU = 6'd35;
  localparam logic [5:0] FN_AND  = 6'd36;
  localparam logic [5:0] FN_OR   = 6'd37;
  localparam logic [5:0] FN_XOR  = 6'd38;
  localparam logic [5:0] FN_NOR  = 6'd39;
  localparam logic [5:0] FN_SLT  = 6'd42;
  localparam logic [5:0] FN_SLTU = 6'd43;
endpackage

// File: rtl/decCtrl.sv
module decCtrl
  import idec_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [5:0]       funct,
  output ctrlStrobes_t     ctrl
);
  ctrlStrobes_t base;

  always_comb begin
    base           = '0;
    base.aluOp     = ALU_ADD;
    base.memSize   = SZ_BYTE;
    base.immKind   = IMM_SIGN;
    base.dstSel    = DST_RT;
  end

  // ALU register-format op for a function code; flags unknown codes
  function automatic ctrlStrobes_t regFormat(input ctrlStrobes_t b, input logic [5:0] fn);
    ctrlStrobes_t c;
    c          = b;
    c.dstSel   = DST_RD;
    c.regWrite = 1'b1;
    case (fn)
      FN_SLL:           c.aluOp = ALU_SLL;
      FN_SRL:           c.aluOp = ALU_SRL;
      FN_SRA:           c.aluOp = ALU_SRA;
      FN_ADD, FN_ADDU:  c.aluOp = ALU_ADD;
      FN_SUB, FN_SUBU:  c.aluOp = ALU_SUB;
      FN_AND:           c.aluOp = ALU_AND;
      FN_OR:            c.aluOp = ALU_OR;
      FN_XOR:           c.aluOp = ALU_XOR;
      FN_NOR:           c.aluOp = ALU_NOR;
      FN_SLT:           c.aluOp = ALU_SLT;
      FN_SLTU:          c.aluOp = ALU_SLTU;
      FN_JR: begin
        c.regWrite = 1'b0;
        c.jumpReg  = 1'b1;
      end
      default: begin
        c         = b;
        c.dstSel  = DST_RD;
        c.illegal = 1'b1;
      end
    endcase
    return c;
  endfunction

  function automatic ctrlStrobes_t aluImm(input ctrlStrobes_t b, input aluSel_e op,
                                          input immKind_e kind);
    ctrlStrobes_t c;
    c           = b;
    c.aluOp     = op;
    c.aluSrcImm = 1'b1;
    c.regWrite  = 1'b1;
    c.immKind   = kind;
    return c;
  endfunction

  function automatic ctrlStrobes_t memAccess(input ctrlStrobes_t b, input logic isLoad,
                                             input memSize_e sz, input logic sgn);
    ctrlStrobes_t c;
    c           = b;
    c.aluSrcImm = 1'b1;
    c.memSize   = sz;
    c.memRead   = isLoad;
    c.memWrite  = !isLoad;
    c.regWrite  = isLoad;
    c.memSigned = isLoad & sgn;
    return c;
  endfunction

  always_comb begin
    ctrl = base;
    case (opcode)
      OP_REG:   ctrl = regFormat(base, funct);
      OP_ADDI,
      OP_ADDIU: ctrl = aluImm(base, ALU_ADD,  IMM_SIGN);
      OP_SLTI:  ctrl = aluImm(base, ALU_SLT,  IMM_SIGN);
      OP_SLTIU: ctrl = aluImm(base, ALU_SLTU, IMM_SIGN);
      OP_ANDI:  ctrl = aluImm(base, ALU_AND,  IMM_ZERO);
      OP_ORI:   ctrl = aluImm(base, ALU_OR,   IMM_ZERO);
      OP_XORI:  ctrl = aluImm(base, ALU_XOR,  IMM_ZERO);
      OP_LUI:   ctrl = aluImm(base, ALU_LUI,  IMM_UPPER);
      OP_LB:    ctrl = memAccess(base, 1'b1, SZ_BYTE, 1'b1);
      OP_LH:    ctrl = memAccess(base, 1'b1, SZ_HALF, 1'b1);
      OP_LW:    ctrl = memAccess(base, 1'b1, SZ_WORD, 1'b1);
      OP_LBU:   ctrl = memAccess(base, 1'b1, SZ_BYTE, 1'b0);
      OP_LHU:   ctrl = memAccess(base, 1'b1, SZ_HALF, 1'b0);
      OP_SB:    ctrl = memAccess(base, 1'b0, SZ_BYTE, 1'b0);
      OP_SH:    ctrl = memAccess(base, 1'b0, SZ_HALF, 1'b0);
      OP_SW:    ctrl = memAccess(base, 1'b0, SZ_WORD, 1'b0);
      OP_BEQ: begin
        ctrl.aluOp = ALU_SUB;
        ctrl.brEq  = 1'b1;
      end
      OP_BNE: begin
        ctrl.aluOp = ALU_SUB;
        ctrl.brNe  = 1'b1;
      end
      OP_J:     ctrl.jump = 1'b1;
      OP_JAL: begin
        ctrl.jump     = 1'b1;
        ctrl.link     = 1'b1;
        ctrl.regWrite = 1'b1;
        ctrl.dstSel   = DST_LINK;
      end
      default:  ctrl.illegal = 1'b1;
    endcase
  end

  // R12: an unrecognised word must leave every enable low
  always_comb begin
    a_r12_illegal_quiet: assert (!ctrl.illegal ||
      !(ctrl.regWrite || ctrl.memRead || ctrl.memWrite || ctrl.brEq || ctrl.brNe ||
        ctrl.jump || ctrl.link || ctrl.jumpReg || ctrl.aluSrcImm));
  end
endmodule

// File: rtl/decDatapath.sv
module decDatapath
  import idec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input  logic [TGT_W-1:0]     fields,
  input  immKind_e             immKind,
  input  dstSel_e              dstSel,
  input  logic                 wrReq,
  output logic [REG_IDX_W-1:0] rsIdx,
  output logic [REG_IDX_W-1:0] rtIdx,
  output logic [REG_IDX_W-1:0] destIdx,
  output logic [REG_IDX_W-1:0] shamt,
  output logic [DATA_W-1:0]    immExt,
  output logic [DATA_W-1:0]    branchOffset,
  output logic [TGT_W+1:0]     jumpOffset,
  output logic                 regWrite
);
  localparam int EXT_W  = DATA_W - IMM_W;
  localparam int RS_LO  = TGT_W - REG_IDX_W;
  localparam int RT_LO  = RS_LO - REG_IDX_W;
  localparam int RD_LO  = RT_LO - REG_IDX_W;
  localparam int SH_LO  = RD_LO - REG_IDX_W;

  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] immSigned;
  logic [DATA_W-1:0] immZero;
  logic [DATA_W-1:0] immUpper;
  logic [REG_IDX_W-1:0] rdIdx;

  assign rsIdx = fields[RS_LO +: REG_IDX_W];
  assign rtIdx = fields[RT_LO +: REG_IDX_W];
  assign rdIdx = fields[RD_LO +: REG_IDX_W];
  assign shamt = fields[SH_LO +: REG_IDX_W];
  assign imm   = fields[IMM_W-1:0];

  generate
    if (EXT_W > 0) begin : gExt
      assign immSigned = {{EXT_W{imm[IMM_W-1]}}, imm};
      assign immZero   = {{EXT_W{1'b0}}, imm};
    end else begin : gNoExt
      assign immSigned = imm[DATA_W-1:0];
      assign immZero   = imm[DATA_W-1:0];
    end
  endgenerate

  assign immUpper     = immZero << IMM_W;
  assign branchOffset = immSigned << 2;
  assign jumpOffset   = {fields, 2'b00};

  always_comb begin
    case (immKind)
      IMM_ZERO:  immExt = immZero;
      IMM_UPPER: immExt = immUpper;
      default:   immExt = immSigned;
    endcase
  end

  always_comb begin
    case (dstSel)
      DST_RD:   destIdx = rdIdx;
      DST_LINK: destIdx = REG_IDX_W'(LINK_REG);
      default:  destIdx = rtIdx;
    endcase
  end

  // register 0 is constant: a write aimed at it is dropped
  assign regWrite = wrReq && (destIdx != '0);
endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import idec_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_IDX_W = 5,
  parameter int LINK_REG  = 31
) (
  input  logic [31:0]          instr,
  output logic [REG_IDX_W-1:0] rsIdx,
  output logic [REG_IDX_W-1:0] rtIdx,
  output logic [REG_IDX_W-1:0] destIdx,
  output logic [REG_IDX_W-1:0] shamt,
  output logic [DATA_W-1:0]    immExt,
  output logic [DATA_W-1:0]    branchOffset,
  output logic [27:0]          jumpOffset,
  output logic [3:0]           aluOp,
  output logic                 aluSrcImm,
  output logic                 regWrite,
  output logic                 memRead,
  output logic                 memWrite,
  output logic [1:0]           memSize,
  output logic                 memSigned,
  output logic                 branchEq,
  output logic                 branchNe,
  output logic                 jump,
  output logic                 jumpLink,
  output logic                 jumpReg,
  output logic                 illegal
);
  ctrlStrobes_t ctrl;

  decCtrl uCtrl (
    .opcode (instr[INSTR_W-1 -: OPC_W]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  decDatapath #(
    .DATA_W    (DATA_W),
    .REG_IDX_W (REG_IDX_W),
    .LINK_REG  (LINK_REG)
  ) uPath (
    .fields       (instr[TGT_W-1:0]),
    .immKind      (ctrl.immKind),
    .dstSel       (ctrl.dstSel),
    .wrReq        (ctrl.regWrite),
    .rsIdx        (rsIdx),
    .rtIdx        (rtIdx),
    .destIdx      (destIdx),
    .shamt        (shamt),
    .immExt       (immExt),
    .branchOffset (branchOffset),
    .jumpOffset   (jumpOffset),
    .regWrite     (regWrite)
  );

  assign aluOp     = ctrl.aluOp;
  assign aluSrcImm = ctrl.aluSrcImm;
  assign memRead   = ctrl.memRead;
  assign memWrite  = ctrl.memWrite;
  assign memSize   = ctrl.memSize;
  assign memSigned = ctrl.memSigned;
  assign branchEq  = ctrl.brEq;
  assign branchNe  = ctrl.brNe;
  assign jump      = ctrl.jump;
  assign jumpLink  = ctrl.link;
  assign jumpReg   = ctrl.jumpReg;
  assign illegal   = ctrl.illegal;

  always_comb begin
    // R2: a link jump must land its return address in the link register
    a_r2_link_dest: assert (!ctrl.link || destIdx == REG_IDX_W'(LINK_REG));
    // R9: stores never also write the register file
    a_r9_store_no_regwr: assert (!ctrl.memWrite || !regWrite);
    // R8: a single access is either a read or a write
    a_r8_rw_exclusive: assert (!(memRead && memWrite));
    // R4: logical immediates arrive with a clear upper half
    a_r4_logic_zero_ext: assert (!(aluSrcImm && (ctrl.aluOp == ALU_AND ||
      ctrl.aluOp == ALU_OR || ctrl.aluOp == ALU_XOR)) || immExt[DATA_W-1:IMM_W] == '0);
    // R12: no register write survives an illegal word
    a_r12_no_write: assert (!illegal || !regWrite);
  end
endmodule

// File: tb/sim_instrDecoder.sv
`timescale 1ns/1ps
module sim_instrDecoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic [31:0] instr = '0;
  logic [4:0]  rsIdx, rtIdx, destIdx, shamt;
  logic [31:0] immExt, branchOffset;
  logic [27:0] jumpOffset;
  logic [3:0]  aluOp;
  logic [1:0]  memSize;
  logic aluSrcImm, regWrite, memRead, memWrite, memSigned;
  logic branchEq, branchNe, jump, jumpLink, jumpReg, illegal;

  instrDecoder u0 (
    .instr, .rsIdx, .rtIdx, .destIdx, .shamt, .immExt, .branchOffset, .jumpOffset,
    .aluOp, .aluSrcImm, .regWrite, .memRead, .memWrite, .memSize, .memSigned,
    .branchEq, .branchNe, .jump, .jumpLink, .jumpReg, .illegal
  );

  typedef struct {
    logic [31:0]  word;
    logic [128:0] exp;
    string        tag;
  } sbItem_t;

  sbItem_t sbQ[$];
  int nChecked = 0;
  int nFailed  = 0;
  bit finished = 1'b0;

  function automatic logic [31:0] rEnc(input int fn, input int rs, input int rt,
                                       input int rd, input int sh);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] iEnc(input int op, input int rs, input int rt,
                                       input logic [15:0] imm);
    return {6'(op), 5'(rs), 5'(rt), imm};
  endfunction

  function automatic logic [31:0] jEnc(input int op, input logic [25:0] tgt);
    return {6'(op), tgt};
  endfunction

  // expected bundle, built directly from the requirement list
  function automatic logic [128:0] model(input logic [31:0] w);
    logic [5:0]  op, fn;
    logic [4:0]  dst;
    logic [31:0] imm, br;
    logic [27:0] jt;
    logic [3:0]  alu;
    logic [1:0]  sz;
    logic src, rw, mr, mw, sg, be, bn, j, jl, jr, il;
    op = w[31:26]; fn = w[5:0];
    dst = (op == 6'd0) ? w[15:11] : w[20:16];
    imm = {{16{w[15]}}, w[15:0]};
    br  = {{14{w[15]}}, w[15:0], 2'b00};
    jt  = {w[25:0], 2'b00};
    alu = 4'd0; sz = 2'd0;
    {src, rw, mr, mw, sg, be, bn, j, jl, jr, il} = '0;
    case (op)
      6'd0: begin
        rw = 1'b1;
        case (fn)
          6'd0:  alu = 4'd8;
          6'd2:  alu = 4'd9;
          6'd3:  alu = 4'd10;
          6'd8:  begin rw = 1'b0; jr = 1'b1; end
          6'd32, 6'd33: alu = 4'd0;
          6'd34, 6'd35: alu = 4'd1;
          6'd36: alu = 4'd2;
          6'd37: alu = 4'd3;
          6'd38: alu = 4'd4;
          6'd39: alu = 4'd5;
          6'd42: alu = 4'd6;
          6'd43: alu = 4'd7;
          default: begin rw = 1'b0; il = 1'b1; end
        endcase
      end
      6'd8, 6'd9: begin src = 1; rw = 1; alu = 4'd0; end
      6'd10: begin src = 1; rw = 1; alu = 4'd6; end
      6'd11: begin src = 1; rw = 1; alu = 4'd7; end
      6'd12: begin src = 1; rw = 1; alu = 4'd2; imm = {16'h0, w[15:0]}; end
      6'd13: begin src = 1; rw = 1; alu = 4'd3; imm = {16'h0, w[15:0]}; end
      6'd14: begin src = 1; rw = 1; alu = 4'd4; imm = {16'h0, w[15:0]}; end
      6'd15: begin src = 1; rw = 1; alu = 4'd11; imm = {w[15:0], 16'h0}; end
      6'd32: begin src = 1; rw = 1; mr = 1; sz = 2'd0; sg = 1; end
      6'd33: begin src = 1; rw = 1; mr = 1; sz = 2'd1; sg = 1; end
      6'd35: begin src = 1; rw = 1; mr = 1; sz = 2'd2; sg = 1; end
      6'd36: begin src = 1; rw = 1; mr = 1; sz = 2'd0; end
      6'd37: begin src = 1; rw = 1; mr = 1; sz = 2'd1; end
      6'd40: begin src = 1; mw = 1; sz = 2'd0; end
      6'd41: begin src = 1; mw = 1; sz = 2'd1; end
      6'd43: begin src = 1; mw = 1; sz = 2'd2; end
      6'd4:  begin be = 1; alu = 4'd1; end
      6'd5:  begin bn = 1; alu = 4'd1; end
      6'd2:  j = 1;
      6'd3:  begin j = 1; jl = 1; rw = 1; dst = 5'd31; end
      default: il = 1;
    endcase
    if (dst == 5'd0) rw = 1'b0;
    return {w[25:21], w[20:16], dst, w[10:6], imm, br, jt, alu,
            src, rw, mr, mw, sz, sg, be, bn, j, jl, jr, il};
  endfunction

  task automatic drive(input logic [31:0] w, input string tag);
    sbItem_t it;
    @(posedge clk);
    instr <= w;
    it.word = w; it.exp = model(w); it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: every result is due in the cycle its word is applied
  always @(negedge clk) begin
    if (!rst && sbQ.size() > 0) begin
      sbItem_t it;
      logic [128:0] act;
      it  = sbQ.pop_front();
      act = {rsIdx, rtIdx, destIdx, shamt, immExt, branchOffset, jumpOffset, aluOp,
             aluSrcImm, regWrite, memRead, memWrite, memSize, memSigned,
             branchEq, branchNe, jump, jumpLink, jumpReg, illegal};
      nChecked++;
      if (act !== it.exp) begin
        nFailed++;
        $display("FAIL %s word=%h actual=%h expected=%h", it.tag, it.word, act, it.exp);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    drive(32'h0, "R1 R3 reset state");
    drive(rEnc(32, 2, 27, 3, 0), "R1 R2 R6 add");
    drive(rEnc(34, 5, 6, 7, 0), "R6 sub");
    drive(rEnc(35, 5, 6, 7, 0), "R6 subu");
    drive(rEnc(36, 1, 2, 4, 0), "R6 and");
    drive(rEnc(37, 1, 2, 4, 0), "R6 or");
    drive(rEnc(38, 1, 2, 4, 0), "R6 xor");
    drive(rEnc(39, 1, 2, 4, 0), "R6 nor");
    drive(rEnc(42, 9, 10, 11, 0), "R6 slt");
    drive(rEnc(43, 9, 10, 11, 0), "R6 sltu");
    drive(rEnc(0, 0, 12, 13, 17), "R1 R6 sll shamt");
    drive(rEnc(2, 0, 12, 13, 31), "R6 srl");
    drive(rEnc(3, 0, 12, 13, 1), "R6 sra");
    drive(rEnc(32, 2, 3, 0, 0), "R3 add to r0");
    drive(rEnc(8, 31, 0, 0, 0), "R11 jr");
    drive(iEnc(8, 22, 21, 16'hFFF0), "R4 R7 addi negative");
    drive(iEnc(9, 1, 2, 16'h7FFF), "R7 addiu");
    drive(iEnc(10, 3, 4, 16'h8001), "R7 slti");
    drive(iEnc(11, 3, 4, 16'h0005), "R7 sltiu");
    drive(iEnc(12, 5, 6, 16'h8000), "R4 R7 andi zero ext");
    drive(iEnc(13, 22, 21, 16'h0080), "R4 R7 ori");
    drive(iEnc(14, 22, 21, 16'hF00F), "R4 R7 xori");
    drive(iEnc(15, 0, 14, 16'h03E8), "R4 R7 lui");
    drive(iEnc(8, 4, 0, 16'h0001), "R3 addi to r0");
    drive(iEnc(35, 22, 18, 16'h0000), "R8 lw");
    drive(iEnc(32, 22, 18, 16'hFFFC), "R8 lb");
    drive(iEnc(36, 22, 18, 16'h0006), "R8 lbu");
    drive(iEnc(33, 22, 18, 16'h0002), "R8 lh");
    drive(iEnc(37, 22, 18, 16'h8002), "R8 lhu");
    drive(iEnc(35, 22, 0, 16'h0004), "R3 R8 lw to r0");
    drive(32'hAE080100, "R9 sw base16 data8 off256");
    drive(iEnc(40, 22, 13, 16'h00C9), "R9 sb");
    drive(iEnc(41, 22, 13, 16'hFFFE), "R9 sh");
    drive(iEnc(4, 3, 0, 16'hFFFA), "R5 R10 beq negative");
    drive(iEnc(5, 0, 3, 16'h0006), "R5 R10 bne");
    drive(jEnc(2, 26'h023EB71), "R5 R11 j");
    drive(jEnc(3, 26'h3FFFFFF), "R2 R11 jal");
    drive(iEnc(63, 7, 8, 16'h1234), "R12 unknown opcode");
    drive(iEnc(6, 7, 8, 16'h1234), "R12 opcode 6");
    drive(rEnc(1, 7, 8, 9, 0), "R12 unknown funct");
    drive(rEnc(24, 7, 8, 9, 3), "R12 funct 24");
    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      finished = 1'b1;
      nChecked++;
      nFailed++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecked, nFailed);
      $finish;
    end
  end
endmodule